// File: doc/BRIEF.md
# Double-Buffered Serial DAC Front End

This block is the digital side of a serial-input digital-to-analog converter. A host writes 16-bit words over a three-wire port made of a frame select, a serial clock and a data line. Bits enter a shift register on falling serial-clock edges while the frame select is low. A completed word waits there until a transfer moves it into the held DAC register. The transfer happens either on a falling edge of the transfer strobe or, when that strobe is kept low, when the frame select rises. The parallel code that goes to the converter core is the low `RES` bits of the held register, with `RES` set to 12 or 14.

A serial output serves two purposes. While the readback input is low, it shifts out the held register as a zero-extended 16-bit word. Otherwise it shows the bit about to leave the input shift register, so several parts can be chained. The output imitates an open-drain pad: it drives low for a 0 and releases the line for a 1.

A falling edge on the zeroing input forces the output code to zero and leaves both registers unchanged. The code stays at zero until the next transfer. A sleep input is passed through as a power-down flag. All pins are sampled by the system clock `clk`. Every result appears two `clk` cycles after the pin change that causes it.

Top module: `serdac_frontend`

## Requirements
- R1: After reset, `code_out` is 0, `zeroed` and `asleep` are 0, and the serial output drives low (`ser_dout_bit`=0, `ser_dout_oe`=1) because the input shift register is cleared.
- R2: On each falling `sck` edge with `frame_n` low, `ser_din` enters bit 0 of the 16-bit shift register and all bits move one place toward bit 15, so bits arrive MSB first. Falling edges while `frame_n` is high are ignored. A frame of any length leaves only the last 16 bits received.
- R3: A falling edge of `xfer_n` copies the shift register into the held register. `code_out` takes bits [RES-1:0] of the word, and bits [15:RES] are dropped.
- R4: While `xfer_n` is low, a rising edge of `frame_n` performs the same transfer.
- R5: Without one of those two transfer events, the held register and `code_out` do not change, including during a frame and on a rising `frame_n` edge with `xfer_n` high.
- R6: A falling edge of `rdbk_n` loads the held code, zero-extended to 16 bits, into a readback register. While `rdbk_n` stays low, `ser_dout_bit` shows its bit 15, and each rising `sck` edge moves the next lower bit up, so the word leaves MSB first.
- R7: While `rdbk_n` is high, `ser_dout_bit` equals bit 15 of the input shift register.
- R8: `ser_dout_oe` is 1 exactly when `ser_dout_bit` is 0, so the line is only ever pulled low.
- R9: A falling edge of `zero_n` forces `code_out` to 0 and sets `zeroed`. The shift register and the held register keep their contents.
- R10: The zeroed state persists when `zero_n` returns high and ends at the next transfer, after which `code_out` follows the held register.
- R11: `asleep` follows the `sleep` input.
- R12: Every output responds exactly two `clk` cycles after the pin change that causes it, and not one cycle after.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples every pin |
| rst | input | 1 | Synchronous active-high reset |
| sck | input | 1 | Serial clock: data is taken on its falling edge, readback advances on its rising edge |
| frame_n | input | 1 | Active-low frame select; its rising edge is the end of a frame |
| ser_din | input | 1 | Serial data in |
| xfer_n | input | 1 | Active-low transfer strobe |
| rdbk_n | input | 1 | Active-low readback enable |
| zero_n | input | 1 | Active-low output zeroing; acts on its falling edge |
| sleep | input | 1 | Power-down request |
| code_out | output | RES | Parallel code to the converter core |
| zeroed | output | 1 | Output is currently forced to zero |
| asleep | output | 1 | Power-down flag |
| ser_dout_bit | output | 1 | Logical value of the serial output |
| ser_dout_oe | output | 1 | Pad pull-down enable: high when driving a 0 |

## Verification
Each pin is registered once, and its edge is compared with the previous sample. The action then lands in a second register, so every output change is due two `clk` cycles after the pin change. The bench changes pins on a falling `clk` edge and reads results on the second falling edge after that, halfway between active edges. One check samples `asleep` a single cycle after `sleep` rises to confirm that it has not yet moved. The checker's port-level properties use the same fixed window, with `$past` depths of 2 and 3.

// File: rtl/serdac_pkg.sv
package serdac_pkg;

    localparam int WORD_W   = 16;

    // pins that need edge detection come first
    localparam int PIN_SCK   = 0;
    localparam int PIN_FRAME = 1;
    localparam int PIN_XFER  = 2;
    localparam int PIN_RDBK  = 3;
    localparam int PIN_ZERO  = 4;
    localparam int NUM_EDGE  = 5;
    // level-only pins
    localparam int PIN_DIN   = 5;
    localparam int PIN_SLEEP = 6;
    localparam int NUM_PINS  = 7;

    // idle level of each pin, loaded into the sampling flops at reset
    localparam logic [NUM_PINS-1:0] PIN_IDLE = 7'b001_1111;

    typedef struct packed {
        logic sck_fall;
        logic sck_rise;
        logic frame_end;
        logic xfer_fall;
        logic rdbk_fall;
        logic zero_fall;
    } pin_evt_t;

    typedef struct packed {
        logic din;
        logic in_frame;
        logic xfer_low;
        logic rdbk_on;
        logic sleep;
    } pin_lvl_t;

    function automatic logic [WORD_W-1:0] push_bit(input logic [WORD_W-1:0] w,
                                                   input logic b);
        return {w[WORD_W-2:0], b};
    endfunction

endpackage

// File: rtl/serdac_pins.sv
module serdac_pins
    import serdac_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic [NUM_PINS-1:0] pins_raw,
    output pin_evt_t            evt,
    output pin_lvl_t            lvl
);

    logic [NUM_PINS-1:0] cur;
    logic [NUM_EDGE-1:0] prv;

    generate
        for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
            logic c_q;
            always_ff @(posedge clk) begin
                if (rst) c_q <= PIN_IDLE[i];
                else     c_q <= pins_raw[i];
            end
            assign cur[i] = c_q;

            if (i < NUM_EDGE) begin : g_edge
                logic p_q;
                always_ff @(posedge clk) begin
                    if (rst) p_q <= PIN_IDLE[i];
                    else     p_q <= c_q;
                end
                assign prv[i] = p_q;
            end
        end
    endgenerate

    always_comb begin
        evt.sck_fall  =  prv[PIN_SCK]   & ~cur[PIN_SCK];
        evt.sck_rise  = ~prv[PIN_SCK]   &  cur[PIN_SCK];
        evt.frame_end = ~prv[PIN_FRAME] &  cur[PIN_FRAME];
        evt.xfer_fall =  prv[PIN_XFER]  & ~cur[PIN_XFER];
        evt.rdbk_fall =  prv[PIN_RDBK]  & ~cur[PIN_RDBK];
        evt.zero_fall =  prv[PIN_ZERO]  & ~cur[PIN_ZERO];

        lvl.din      =  cur[PIN_DIN];
        lvl.in_frame = ~cur[PIN_FRAME];
        lvl.xfer_low = ~cur[PIN_XFER];
        lvl.rdbk_on  = ~cur[PIN_RDBK];
        lvl.sleep    =  cur[PIN_SLEEP];
    end

endmodule

// File: rtl/serdac_shift.sv
module serdac_shift
    import serdac_pkg::*;
#(
    parameter int RES = 12
)(
    input  logic           clk,
    input  logic           rst,
    input  logic           sck_fall,
    input  logic           in_frame,
    input  logic           din,
    output logic [RES-1:0] low_code,
    output logic           top_bit
);

    logic [WORD_W-1:0] sh_q;

    always_ff @(posedge clk) begin
        if (rst)                       sh_q <= '0;
        else if (sck_fall && in_frame) sh_q <= push_bit(sh_q, din);
    end

    assign low_code = sh_q[RES-1:0];
    assign top_bit  = sh_q[WORD_W-1];

endmodule

// File: rtl/serdac_hold.sv
module serdac_hold #(
    parameter int RES = 12
)(
    input  logic           clk,
    input  logic           rst,
    input  logic           xfer_fall,
    input  logic           frame_end,
    input  logic           xfer_low,
    input  logic           zero_fall,
    input  logic           sleep_lvl,
    input  logic [RES-1:0] new_code,
    output logic [RES-1:0] held_code,
    output logic [RES-1:0] code_out,
    output logic           zeroed,
    output logic           asleep
);

    logic           load;
    logic [RES-1:0] held_q;
    logic           zero_q;
    logic           sleep_q;

    assign load = xfer_fall || (frame_end && xfer_low);

    always_ff @(posedge clk) begin
        if (rst) begin
            held_q  <= '0;
            zero_q  <= 1'b0;
            sleep_q <= 1'b0;
        end else begin
            sleep_q <= sleep_lvl;
            if (load)           held_q <= new_code;
            if (zero_fall)      zero_q <= 1'b1;
            else if (load)      zero_q <= 1'b0;
        end
    end

    assign held_code = held_q;
    assign code_out  = zero_q ? '0 : held_q;
    assign zeroed    = zero_q;
    assign asleep    = sleep_q;

endmodule

// File: rtl/serdac_readout.sv
module serdac_readout
    import serdac_pkg::*;
#(
    parameter int RES = 12
)(
    input  logic           clk,
    input  logic           rst,
    input  logic           rdbk_fall,
    input  logic           rdbk_on,
    input  logic           sck_rise,
    input  logic [RES-1:0] held_code,
    input  logic           chain_bit,
    output logic           dout_bit,
    output logic           dout_oe
);

    localparam int PAD_W = WORD_W - RES;

    logic [WORD_W-1:0] rb_q;
    logic              sel_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            rb_q  <= '0;
            sel_q <= 1'b0;
        end else begin
            sel_q <= rdbk_on;
            if (rdbk_fall)             rb_q <= {{PAD_W{1'b0}}, held_code};
            else if (rdbk_on && sck_rise) rb_q <= push_bit(rb_q, 1'b0);
        end
    end

    assign dout_bit = sel_q ? rb_q[WORD_W-1] : chain_bit;
    assign dout_oe  = ~dout_bit;

endmodule

// File: rtl/serdac_frontend.sv
module serdac_frontend
    import serdac_pkg::*;
#(
    parameter int RES = 12
)(
    input  logic           clk,
    input  logic           rst,
    input  logic           sck,
    input  logic           frame_n,
    input  logic           ser_din,
    input  logic           xfer_n,
    input  logic           rdbk_n,
    input  logic           zero_n,
    input  logic           sleep,
    output logic [RES-1:0] code_out,
    output logic           zeroed,
    output logic           asleep,
    output logic           ser_dout_bit,
    output logic           ser_dout_oe
);

    logic [NUM_PINS-1:0] pins_raw;
    pin_evt_t            evt;
    pin_lvl_t            lvl;
    logic [RES-1:0]      shift_code;
    logic                shift_top;
    logic [RES-1:0]      held_code;

    always_comb begin
        pins_raw            = '0;
        pins_raw[PIN_SCK]   = sck;
        pins_raw[PIN_FRAME] = frame_n;
        pins_raw[PIN_XFER]  = xfer_n;
        pins_raw[PIN_RDBK]  = rdbk_n;
        pins_raw[PIN_ZERO]  = zero_n;
        pins_raw[PIN_DIN]   = ser_din;
        pins_raw[PIN_SLEEP] = sleep;
    end

    serdac_pins u_pins (
        .clk      (clk),
        .rst      (rst),
        .pins_raw (pins_raw),
        .evt      (evt),
        .lvl      (lvl)
    );

    serdac_shift #(.RES(RES)) u_shift (
        .clk      (clk),
        .rst      (rst),
        .sck_fall (evt.sck_fall),
        .in_frame (lvl.in_frame),
        .din      (lvl.din),
        .low_code (shift_code),
        .top_bit  (shift_top)
    );

    serdac_hold #(.RES(RES)) u_hold (
        .clk       (clk),
        .rst       (rst),
        .xfer_fall (evt.xfer_fall),
        .frame_end (evt.frame_end),
        .xfer_low  (lvl.xfer_low),
        .zero_fall (evt.zero_fall),
        .sleep_lvl (lvl.sleep),
        .new_code  (shift_code),
        .held_code (held_code),
        .code_out  (code_out),
        .zeroed    (zeroed),
        .asleep    (asleep)
    );

    serdac_readout #(.RES(RES)) u_readout (
        .clk       (clk),
        .rst       (rst),
        .rdbk_fall (evt.rdbk_fall),
        .rdbk_on   (lvl.rdbk_on),
        .sck_rise  (evt.sck_rise),
        .held_code (held_code),
        .chain_bit (shift_top),
        .dout_bit  (ser_dout_bit),
        .dout_oe   (ser_dout_oe)
    );

endmodule

// File: rtl/serdac_frontend_chk.sv
module serdac_frontend_chk #(
    parameter int RES = 12
)(
    input logic           clk,
    input logic           rst,
    input logic           frame_n,
    input logic           xfer_n,
    input logic           zero_n,
    input logic           sleep,
    input logic [RES-1:0] code_out,
    input logic           zeroed,
    input logic           asleep
);

    // cycles since reset, so that $past never reaches into reset
    logic [2:0] age_q;
    logic       armed;

    always_ff @(posedge clk) begin
        if (rst)              age_q <= '0;
        else if (age_q != 3'd7) age_q <= age_q + 3'd1;
    end
    assign armed = (age_q >= 3'd4);

    // R5: with no transfer and no zeroing in the window, the code holds
    a_r5_code_holds: assert property (@(posedge clk) disable iff (rst || !armed)
        (!($past(xfer_n,3) && !$past(xfer_n,2)) &&
         !(!$past(frame_n,3) && $past(frame_n,2) && !$past(xfer_n,2)) &&
         !($past(zero_n,3) && !$past(zero_n,2)))
        |-> $stable(code_out));

    // R9: a zeroing edge forces the code to zero two cycles later
    a_r9_zero_forces: assert property (@(posedge clk) disable iff (rst || !armed)
        ($past(zero_n,3) && !$past(zero_n,2)) |-> (zeroed && code_out == '0));

    // R10: a transfer without a zeroing edge ends the zeroed state
    a_r10_xfer_releases: assert property (@(posedge clk) disable iff (rst || !armed)
        ((($past(xfer_n,3) && !$past(xfer_n,2)) ||
          (!$past(frame_n,3) && $past(frame_n,2) && !$past(xfer_n,2))) &&
         !($past(zero_n,3) && !$past(zero_n,2)))
        |-> !zeroed);

    // R11 and R12: sleep flag follows its pin with a two-cycle lag
    a_r11_sleep_follows: assert property (@(posedge clk) disable iff (rst || !armed)
        asleep == $past(sleep,2));

    // R10: while zeroed, the converter sees a zero code
    a_r10_zeroed_code: assert property (@(posedge clk) disable iff (rst)
        zeroed |-> code_out == '0);

endmodule

bind serdac_frontend serdac_frontend_chk #(.RES(RES)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .frame_n  (frame_n),
    .xfer_n   (xfer_n),
    .zero_n   (zero_n),
    .sleep    (sleep),
    .code_out (code_out),
    .zeroed   (zeroed),
    .asleep   (asleep)
);

// File: tb/serdac_frontend_bench.sv
`timescale 1ns/1ps
module serdac_frontend_bench;

    localparam int RES = 12;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic           sck = 1'b1;
    logic           frame_n = 1'b1;
    logic           ser_din = 1'b0;
    logic           xfer_n = 1'b1;
    logic           rdbk_n = 1'b1;
    logic           zero_n = 1'b1;
    logic           sleep = 1'b0;
    logic [RES-1:0] code_out;
    logic           zeroed;
    logic           asleep;
    logic           ser_dout_bit;
    logic           ser_dout_oe;

    int n_tests = 0;
    int n_fail  = 0;

    always #2.5 clk = ~clk;

    serdac_frontend #(.RES(RES)) u_serdac_frontend (
        .clk          (clk),
        .rst          (rst),
        .sck          (sck),
        .frame_n      (frame_n),
        .ser_din      (ser_din),
        .xfer_n       (xfer_n),
        .rdbk_n       (rdbk_n),
        .zero_n       (zero_n),
        .sleep        (sleep),
        .code_out     (code_out),
        .zeroed       (zeroed),
        .asleep       (asleep),
        .ser_dout_bit (ser_dout_bit),
        .ser_dout_oe  (ser_dout_oe)
    );

    // {word sent, expected code for RES=12}
    localparam logic [31:0] VEC [6] = '{
        {16'hABCD, 16'h0BCD},
        {16'hFFFF, 16'h0FFF},
        {16'h0000, 16'h0000},
        {16'h8001, 16'h0001},
        {16'h7FFE, 16'h0FFE},
        {16'h5A5A, 16'h0A5A}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // results are due two clk cycles after a pin change made at a falling edge
    task automatic settle();
        repeat (2) @(negedge clk);
    endtask

    task automatic send_bits(input logic [31:0] bits, input int n);
        for (int i = n - 1; i >= 0; i--) begin
            ser_din = bits[i];
            settle();
            sck = 1'b0;
            settle();
            sck = 1'b1;
            settle();
        end
    endtask

    task automatic frame(input logic [31:0] bits, input int n);
        frame_n = 1'b0;
        settle();
        send_bits(bits, n);
        frame_n = 1'b1;
        settle();
    endtask

    task automatic pulse_xfer();
        xfer_n = 1'b0;
        settle();
        xfer_n = 1'b1;
        settle();
    endtask

    task automatic read_back(output logic [15:0] w);
        rdbk_n = 1'b0;
        settle();
        for (int b = 15; b >= 0; b--) begin
            w[b] = ser_dout_bit;
            sck = 1'b0;
            settle();
            sck = 1'b1;
            settle();
        end
        rdbk_n = 1'b1;
        settle();
    endtask

    initial begin
        repeat (400000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] prev_exp;
        logic [15:0] rw;

        repeat (4) @(negedge clk);
        rst = 1'b0;
        settle();

        // R1 reset state
        chk("R1 code", 32'(code_out), 32'h0);
        chk("R1 zeroed", 32'(zeroed), 32'h0);
        chk("R1 asleep", 32'(asleep), 32'h0);
        chk("R1 sdo bit", 32'(ser_dout_bit), 32'h0);
        chk("R1 sdo oe", 32'(ser_dout_oe), 32'h1);

        // table walk: alternate strobe transfer and frame-end transfer
        prev_exp = 32'h0;
        for (int i = 0; i < 6; i++) begin
            if (i % 2 == 0) begin
                xfer_n = 1'b1;
                frame(32'(VEC[i][31:16]), 16);
                chk("R5 no transfer at frame end with strobe high", 32'(code_out), prev_exp);
                pulse_xfer();
                chk("R3 strobe transfer", 32'(code_out), 32'(VEC[i][15:0]));
            end else begin
                xfer_n = 1'b0;
                settle();
                chk("R5 held code before frame", 32'(code_out), prev_exp);
                frame_n = 1'b0;
                settle();
                send_bits(32'(VEC[i][31:16]), 16);
                chk("R5 held code during frame", 32'(code_out), prev_exp);
                frame_n = 1'b1;
                settle();
                chk("R4 frame-end transfer", 32'(code_out), 32'(VEC[i][15:0]));
                xfer_n = 1'b1;
                settle();
            end
            prev_exp = 32'(VEC[i][15:0]);
        end

        // R2: clocks outside a frame are ignored (shift reg still 5A5A)
        send_bits(32'h1234, 16);
        pulse_xfer();
        chk("R2 ignored outside frame", 32'(code_out), 32'h0A5A);
        chk("R7 chain bit of 5A5A", 32'(ser_dout_bit), 32'h0);
        chk("R8 oe low-drive", 32'(ser_dout_oe), 32'h1);

        // R2: long frame keeps the last 16 bits
        frame(32'h000F_0123, 20);
        pulse_xfer();
        chk("R2 long frame", 32'(code_out), 32'h0123);

        frame(32'h8421, 16);
        chk("R7 chain bit of 8421", 32'(ser_dout_bit), 32'h1);
        chk("R8 oe released", 32'(ser_dout_oe), 32'h0);
        pulse_xfer();
        chk("R3 upper bits dropped", 32'(code_out), 32'h0421);

        // R2: short frame shifts in only its own bits
        frame(32'hF, 4);
        pulse_xfer();
        chk("R2 short frame", 32'(code_out), 32'h021F);

        // R6 readback of the held register
        read_back(rw);
        chk("R6 readback word", 32'(rw), 32'h021F);
        chk("R7 chain restored after readback", 32'(ser_dout_bit), 32'h0);

        // R9 / R10 zeroing
        zero_n = 1'b0;
        settle();
        chk("R9 code zeroed", 32'(code_out), 32'h0);
        chk("R9 zeroed flag", 32'(zeroed), 32'h1);
        zero_n = 1'b1;
        settle();
        chk("R10 still zeroed", 32'(code_out), 32'h0);
        read_back(rw);
        chk("R9 held register kept", 32'(rw), 32'h021F);
        pulse_xfer();
        chk("R10 released by transfer", 32'(zeroed), 32'h0);
        chk("R9 shift register kept", 32'(code_out), 32'h021F);

        // R11 / R12 sleep flag and latency
        sleep = 1'b1;
        @(negedge clk);
        chk("R12 not yet after one cycle", 32'(asleep), 32'h0);
        @(negedge clk);
        chk("R11 asleep set", 32'(asleep), 32'h1);
        sleep = 1'b0;
        settle();
        chk("R11 asleep clear", 32'(asleep), 32'h0);

        // R12 transfer latency
        frame(32'h0777, 16);
        xfer_n = 1'b0;
        @(negedge clk);
        chk("R12 transfer not after one cycle", 32'(code_out), 32'h021F);
        @(negedge clk);
        chk("R12 transfer after two cycles", 32'(code_out), 32'h0777);
        xfer_n = 1'b1;
        settle();

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule